// File: doc/BRIEF.md
# Edge-Programmable Interrupt Capture Unit

This block watches eight single-bit input lines and raises one shared interrupt when a programmed transition happens on any of them. Each line has two enable bits, one for low-to-high and one for high-to-low transitions. A channel can therefore react to rising edges only, to falling edges only, or to both. Every qualified transition sets a sticky flag for its direction and channel. The interrupt output is the OR of all sixteen flags.

Software reaches the block through a byte-wide register port with a 4-bit offset. It programs the two enable bytes and reads the two flag bytes, the combined pending bit and the synchronized input levels. Reading a per-channel clear offset drops both flags of that channel. A write to the pending offset pulls the interrupt output low for a fixed number of clocks, so that an edge-sensitive host interrupt input shared with other sources sees a new edge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, both enable bytes read 0x00, both flag bytes read 0x00, and `irq_out` is low.
- R2: A low-to-high change on input n, with bit n of the rising-enable byte (offset 0x8) set, sets bit n of the rising-flag byte (offset 0xB). Each input passes through two synchronizing flops before edge detection.
- R3: A high-to-low change on input n, with bit n of the falling-enable byte (offset 0x9) set, sets bit n of the falling-flag byte (offset 0xC).
- R4: A transition in a direction whose enable bit is clear never sets that direction's flag.
- R5: Once set, a flag holds through later transitions on its input until it is cleared.
- R6: A read of offset n (0 to 7) clears both flags of channel n and no other flag. Such a read returns 0x00. A write to offsets 0 to 7, or to a flag offset, changes no flag.
- R7: `irq_out` is high exactly when at least one flag is set and no forced-low window is running. A read of offset 0xA returns that OR of the flags in bit 0, with bits 7:1 zero.
- R8: A write to offset 0xA holds `irq_out` low for PULSE_CYC clock cycles, counted from the write edge. A further write during the window restarts the count.
- R9: A qualified transition detected in the same cycle as the clear read of its channel wins, so the flag ends set.
- R10: Writes to offsets 0x8 and 0x9 store the data byte, bit n belonging to channel n, and reads of those offsets return the stored byte.
- R11: A read of offset 0xD returns the synchronized level of the eight inputs, bit n for input n.
- R12: Reads of offsets 0xE and 0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 8 | Monitored input lines, one per channel |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the edge that takes the read, zero otherwise |
| irq_out | output | 1 | Shared interrupt request, active high |

## Verification
A wrong flag shows up in three places. It appears in the flag byte read one edge later, in bit 0 of the pending register, and on `irq_out`, which follows the flag state without a register. Transitions take three edges from the input pin to the flag, so the bench samples only after that latency. A misdecoded clear or a wrong priority at the clear edge changes the next flag-byte read, and a wrong window counter moves the `irq_out` recovery edge off cycle PULSE_CYC.

// File: rtl/eic_pkg.sv
// Shared constants for the edge-programmable interrupt capture unit.
// Assumes a 4-bit register offset; offsets 0..NUM_CH-1 are channel clears.
package eic_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_RISE_EN   = 4'h8,
        OFS_FALL_EN   = 4'h9,
        OFS_PENDING   = 4'hA,
        OFS_RISE_FLAG = 4'hB,
        OFS_FALL_FLAG = 4'hC,
        OFS_LEVEL     = 4'hD
    } reg_ofs_e;

endpackage

// File: rtl/eic_sync.sv
// Two-flop synchronizer plus a registered previous sample per line.
// Produces one-cycle rise/fall indications on the synchronized level.
// Assumes inputs may be asynchronous to clk.
module eic_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;
    logic [WIDTH-1:0] prev;

    // Synchronizer chain and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
        end else begin
            stage1 <= raw_in;
            stage2 <= stage1;
            prev   <= stage2;
        end
    end

    // Edge indications against the previous sample.
    always_comb begin
        level = stage2;
        rise  = stage2 & ~prev;
        fall  = ~stage2 & prev;
    end

    // A rise indication cannot last two cycles in a row on the same line.
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/eic_chan.sv
// One channel's pair of sticky event flags. A qualified edge sets its flag;
// a clear drops both flags unless a qualified edge arrives in the same cycle.
module eic_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic en_rise,
    input  logic en_fall,
    input  logic clr,
    output logic flag_rise,
    output logic flag_fall
);
    logic hit_rise;
    logic hit_fall;

    // Qualify detected edges with their enables.
    always_comb begin
        hit_rise = rise & en_rise;
        hit_fall = fall & en_fall;
    end

    // Sticky flags: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_rise <= 1'b0;
            flag_fall <= 1'b0;
        end else begin
            flag_rise <= hit_rise | (flag_rise & ~clr);
            flag_fall <= hit_fall | (flag_fall & ~clr);
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rise && !clr) |=> flag_rise);
    assert_disabled_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_rise && !flag_rise) |=> !flag_rise);
    assert_disabled_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_fall && !flag_fall) |=> !flag_fall);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise && !fall) |=> (!flag_rise && !flag_fall));
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise && en_rise) |=> flag_rise);
endmodule

// File: rtl/eic_pulse.sv
// Forced-low window timer. A start loads PULSE_CYC; the window is active
// while the count is non-zero. A start during the window reloads the count.
module eic_pulse #(
    parameter int unsigned PULSE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int unsigned CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] count;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start)
            count <= CW'(PULSE_CYC);
        else if (count != '0)
            count <= count - 1'b1;
    end

    // Window flag.
    always_comb active = (count != '0);

    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
endmodule

// File: rtl/eic_regs.sv
// Register port: enable bytes, read mux, clear-on-read decode and the
// window start strobe. Read data is registered and zero when idle.
module eic_regs
    import eic_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] flags_rise,
    input  logic [NUM_CH-1:0] flags_fall,
    input  logic [NUM_CH-1:0] level,
    input  logic              pending,
    output logic [NUM_CH-1:0] en_rise,
    output logic [NUM_CH-1:0] en_fall,
    output logic [NUM_CH-1:0] clr,
    output logic              pulse_start,
    output logic [NUM_CH-1:0] rdata
);
    logic [NUM_CH-1:0] rd_val;

    // Enable byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_rise <= '0;
            en_fall <= '0;
        end else if (wr) begin
            if (addr == OFS_RISE_EN) en_rise <= wdata;
            if (addr == OFS_FALL_EN) en_fall <= wdata;
        end
    end

    // Per-channel clear strobes decoded from reads of low offsets.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_clr
        always_comb clr[n] = rd && (addr == ADDR_W'(n));
    end

    // Window start on a write to the pending offset.
    always_comb pulse_start = wr && (addr == OFS_PENDING);

    // Read value selection.
    always_comb begin
        case (addr)
            OFS_RISE_EN:   rd_val = en_rise;
            OFS_FALL_EN:   rd_val = en_fall;
            OFS_PENDING:   rd_val = {{(NUM_CH-1){1'b0}}, pending};
            OFS_RISE_FLAG: rd_val = flags_rise;
            OFS_FALL_FLAG: rd_val = flags_fall;
            OFS_LEVEL:     rd_val = level;
            default:       rd_val = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd ? rd_val : '0;
    end

    assert_enable_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_RISE_EN) |=> (en_rise == $past(wdata)));
    assert_clear_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
endmodule

// File: rtl/edge_irq_ctrl.sv
// Top of the edge-programmable interrupt capture unit. Synchronizes the
// inputs, keeps two sticky flags per channel, ORs them into one interrupt
// and masks that interrupt during a software-started forced-low window.
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned PULSE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sig_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    output logic              irq_out
);
    logic [NUM_CH-1:0] level, rise, fall;
    logic [NUM_CH-1:0] en_rise, en_fall, clr;
    logic [NUM_CH-1:0] flags_rise, flags_fall;
    logic              pending, pulse_start, force_low;

    eic_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(sig_in),
        .level(level), .rise(rise), .fall(fall)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        eic_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .rise(rise[n]), .fall(fall[n]),
            .en_rise(en_rise[n]), .en_fall(en_fall[n]),
            .clr(clr[n]),
            .flag_rise(flags_rise[n]), .flag_fall(flags_fall[n])
        );
    end

    eic_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
        .flags_rise(flags_rise), .flags_fall(flags_fall),
        .level(level), .pending(pending),
        .en_rise(en_rise), .en_fall(en_fall), .clr(clr),
        .pulse_start(pulse_start), .rdata(bus_rdata)
    );

    eic_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(pulse_start), .active(force_low)
    );

    // Combined request, masked during the forced-low window.
    always_comb begin
        pending = |{flags_rise, flags_fall};
        irq_out = pending & ~force_low;
    end

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rise == '0 && flags_fall == '0) |-> !irq_out);
    assert_window_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> !irq_out);
endmodule

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;
    localparam int unsigned P = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sig_in = 8'h00;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    edge_irq_ctrl #(.NUM_CH(8), .PULSE_CYC(P)) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        sig_in = v;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 irq", {7'b0, irq_out}, 8'h00);
        bus_read(4'h8, d); check("R1 rise enable", d, 8'h00);
        bus_read(4'h9, d); check("R1 fall enable", d, 8'h00);
        bus_read(4'hB, d); check("R1 rise flags", d, 8'h00);
        bus_read(4'hC, d); check("R1 fall flags", d, 8'h00);
    endtask

    task automatic t_enables;
        logic [7:0] d;
        bus_write(4'h8, 8'hA5);
        bus_write(4'h9, 8'h3C);
        bus_read(4'h8, d); check("R10 rise enable", d, 8'hA5);
        bus_read(4'h9, d); check("R10 fall enable", d, 8'h3C);
    endtask

    task automatic t_rise;
        logic [7:0] d;
        drive(8'hFF);
        bus_read(4'hB, d); check("R2/R4 rise flags", d, 8'hA5);
        bus_read(4'hC, d); check("R4 fall flags", d, 8'h00);
        check("R7 irq set", {7'b0, irq_out}, 8'h01);
        bus_read(4'hA, d); check("R7 pending", d, 8'h01);
        bus_read(4'hD, d); check("R11 level", d, 8'hFF);
    endtask

    task automatic t_hold;
        logic [7:0] d;
        drive(8'h00);
        bus_read(4'hC, d); check("R3 fall flags", d, 8'h3C);
        bus_read(4'hD, d); check("R11 level low", d, 8'h00);
        drive(8'hFF);
        bus_read(4'hB, d); check("R5 rise flags held", d, 8'hA5);
    endtask

    task automatic t_clear;
        logic [7:0] d;
        bus_write(4'h0, 8'hFF);
        bus_write(4'hB, 8'h00);
        bus_read(4'hB, d); check("R6 write ignored", d, 8'hA5);
        bus_read(4'h0, d); check("R6 clear read data", d, 8'h00);
        bus_read(4'hB, d); check("R6 rise after clr0", d, 8'hA4);
        bus_read(4'hC, d); check("R6 fall after clr0", d, 8'h3C);
        bus_read(4'h2, d);
        bus_read(4'hB, d); check("R6 rise after clr2", d, 8'hA0);
        bus_read(4'hC, d); check("R6 fall after clr2", d, 8'h38);
        for (int n = 0; n < 8; n++) bus_read(4'(n), d);
        bus_read(4'hB, d); check("R6 rise all clear", d, 8'h00);
        bus_read(4'hC, d); check("R6 fall all clear", d, 8'h00);
        check("R7 irq idle", {7'b0, irq_out}, 8'h00);
        bus_read(4'hA, d); check("R7 pending idle", d, 8'h00);
    endtask

    task automatic t_pulse;
        logic [7:0] d;
        drive(8'h00);
        check("R8 irq before window", {7'b0, irq_out}, 8'h01);
        bus_write(4'hA, 8'h00);
        check("R8 low at start", {7'b0, irq_out}, 8'h00);
        repeat (9) @(posedge clk);
        #1 check("R8 low mid window", {7'b0, irq_out}, 8'h00);
        bus_write(4'hA, 8'h00);
        repeat (P - 1) @(posedge clk);
        #1 check("R8 restarted window still low", {7'b0, irq_out}, 8'h00);
        @(posedge clk);
        #1 check("R8 irq back after window", {7'b0, irq_out}, 8'h01);
        for (int n = 0; n < 8; n++) bus_read(4'(n), d);
        check("R7 irq idle after clear", {7'b0, irq_out}, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        bus_write(4'h8, 8'hFF);
        @(negedge clk);
        sig_in = 8'h02;
        @(posedge clk);
        @(posedge clk); #1;
        bus_read(4'h1, d);
        bus_read(4'hB, d); check("R9 edge wins over clear", d, 8'h02);
        bus_read(4'h1, d);
        bus_read(4'hB, d); check("R6 later clear", d, 8'h00);
    endtask

    task automatic t_unused;
        logic [7:0] d;
        bus_read(4'hE, d); check("R12 offset E", d, 8'h00);
        bus_read(4'hF, d); check("R12 offset F", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_enables;
        t_rise;
        t_hold;
        t_clear;
        t_pulse;
        t_collide;
        t_unused;
        done = 1'b1;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report;
        end
    end
endmodule